// File: doc/BRIEF.md
# Dual-Comparator Window Monitor Logic

This block is the digital back end of one voltage-monitor channel. An analog front end delivers two raw comparator bits, `cmp_a_raw` and `cmp_b_raw`. Each bit is 1 while the sensed voltage is above its own trip point. The block turns them into two status bits for the serial status link and for the local fast-output logic. The B status always follows comparator B. The A status reports either comparator A itself or a window flag, selected by configuration. The window flag is `B AND NOT A`, which is 1 only while the input sits between the two thresholds. It means that only when threshold A is programmed above threshold B.

Each status path goes through its own glitch filter. The filter is a per-bit counter: a status bit takes a new value only after the selected source has held that value for `FILTER_LEN` consecutive clocks, and any return to the old value restarts the count. At the default of 384 clocks, the filter adds about 48 µs at 8 MHz. With the filter switched off, a status bit follows its source after one clock.

While `analog_good` is low (calibration still running), both outputs are forced to 0 and the counters are cleared. The window select and filter enable are captured only during that time and are frozen while `analog_good` is high.

Top module: `wmon_channel`

## Requirements
- R1: In direct mode (window select 0), `stat_a` reports comparator A, where 1 means the input is above trip point A.
- R2: `stat_b` reports comparator B in both window and direct mode.
- R3: In window mode (window select 1), `stat_a` reports `cmp_b_raw & ~cmp_a_raw`. With A above B, the input states below B, between the thresholds and above A (raw A,B = 0,0 / 0,1 / 1,1) give 0, 1, 0.
- R4: With the filter disabled, a status bit equals its source as sampled at the previous rising clock edge.
- R5: With the filter enabled, a status bit changes only at the edge that samples its new source value for the `FILTER_LEN`-th consecutive time. A single sample of the old value restarts the count.
- R6: On any edge where `analog_good` is sampled low, both status bits become 0 and the filter counts are discarded. A partial count made before the drop does not shorten the next qualification.
- R7: `cfg_window_sel` and `cfg_filter_en` are captured only on edges where `analog_good` is low. Changes while it is high have no effect on the outputs.
- R8: Asserting `rst_n` low drives both status bits to 0 at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| analog_good | input | 1 | High once front-end calibration is done; low holds status invalid |
| cfg_window_sel | input | 1 | 1 selects the window flag on `stat_a`, 0 selects comparator A |
| cfg_filter_en | input | 1 | 1 enables the glitch filters |
| cmp_a_raw | input | 1 | Raw comparator A, 1 when above trip point A |
| cmp_b_raw | input | 1 | Raw comparator B, 1 when above trip point B |
| stat_a | output | 1 | Filtered A status (comparator A or window flag) |
| stat_b | output | 1 | Filtered B status |

## Verification
The assertions assume that the comparator bits and `analog_good` are synchronous to `clk` and stable around each rising edge. They also assume that `rst_n` is released away from an edge. The stimulus respects this by changing every input only at the falling edge. The window assertion checks only the logical function: it does not require thresholds A > B, since the block cannot see them. The stimulus still follows the A-above-B ordering in the directed window cases and also drives the impossible pattern A=1, B=0 in the random phase. Configuration changes are applied both while `analog_good` is low and while it is high, so the freeze property is tested from both sides.

// File: rtl/wmon_pkg.sv
package wmon_pkg;

  typedef enum logic {
    ASRC_DIRECT = 1'b0,
    ASRC_WINDOW = 1'b1
  } wmon_asrc_e;

  typedef struct packed {
    wmon_asrc_e a_source;
    logic       filter_en;
  } wmon_cfg_t;

  localparam int unsigned WMON_NUM_PATHS = 2;
  localparam int unsigned WMON_PATH_A    = 0;
  localparam int unsigned WMON_PATH_B    = 1;

endpackage

// File: rtl/wmon_cfg_hold.sv
module wmon_cfg_hold
  import wmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      analog_good,
  input  wmon_cfg_t cfg_in,
  output wmon_cfg_t cfg_q
);

  wmon_cfg_t cfg_d;
  logic      cfg_capture;

  // Capture only while the channel is held invalid.
  assign cfg_capture = ~analog_good;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_capture) begin
      cfg_d = cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{a_source: ASRC_DIRECT, filter_en: 1'b0};
    end else begin
      cfg_q <= cfg_d;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(analog_good)) |-> $stable(cfg_q)) // R7
    else $error("configuration moved while analog_good high");

endmodule

// File: rtl/wmon_src_mux.sv
module wmon_src_mux
  import wmon_pkg::*;
(
  input  wmon_asrc_e                  a_source,
  input  logic                        cmp_a,
  input  logic                        cmp_b,
  output logic [WMON_NUM_PATHS-1:0]   src
);

  logic inside_window;

  // Between thresholds: above B but not above A.
  assign inside_window = cmp_b & ~cmp_a;

  always_comb begin
    src = '0;
    unique case (a_source)
      ASRC_WINDOW: src[WMON_PATH_A] = inside_window;
      default:     src[WMON_PATH_A] = cmp_a;
    endcase
    src[WMON_PATH_B] = cmp_b;
  end

endmodule

// File: rtl/wmon_glitch_filter.sv
module wmon_glitch_filter #(
  parameter int unsigned FILTER_LEN = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic filt_en,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;
  localparam logic [CW-1:0] LIM_ON  = CW'(FILTER_LEN - 1);
  localparam logic [CW-1:0] LIM_OFF = '0;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;
  logic [CW-1:0] limit;
  logic          differs;
  logic          qualified;

  assign limit     = filt_en ? LIM_ON : LIM_OFF;
  assign differs   = (din != q_q);
  assign qualified = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (!run) begin
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (!differs) begin
      cnt_d = '0;
    end else if (qualified) begin
      q_d   = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign dout = q_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_ON) // R5
    else $error("filter count beyond limit");

  AST_CHANGE_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && (dout != $past(dout))) |-> (dout == $past(din))) // R5
    else $error("filtered bit took a value its source never had");

  AST_CLEARED_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(run)) |-> (!dout && (cnt_q == '0))) // R6
    else $error("filter not cleared while invalid");

endmodule

// File: rtl/wmon_channel.sv
module wmon_channel
  import wmon_pkg::*;
#(
  parameter int unsigned FILTER_LEN = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic analog_good,
  input  logic cfg_window_sel,
  input  logic cfg_filter_en,
  input  logic cmp_a_raw,
  input  logic cmp_b_raw,
  output logic stat_a,
  output logic stat_b
);

  wmon_cfg_t                   cfg_in;
  wmon_cfg_t                   cfg_q;
  logic [WMON_NUM_PATHS-1:0]   src;
  logic [WMON_NUM_PATHS-1:0]   filt;

  assign cfg_in.a_source  = cfg_window_sel ? ASRC_WINDOW : ASRC_DIRECT;
  assign cfg_in.filter_en = cfg_filter_en;

  wmon_cfg_hold u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .analog_good(analog_good),
    .cfg_in     (cfg_in),
    .cfg_q      (cfg_q)
  );

  wmon_src_mux u_mux (
    .a_source(cfg_q.a_source),
    .cmp_a   (cmp_a_raw),
    .cmp_b   (cmp_b_raw),
    .src     (src)
  );

  for (genvar g = 0; g < WMON_NUM_PATHS; g++) begin : g_path
    wmon_glitch_filter #(.FILTER_LEN(FILTER_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (analog_good),
      .filt_en(cfg_q.filter_en),
      .din    (src[g]),
      .dout   (filt[g])
    );
  end

  assign stat_a = filt[WMON_PATH_A];
  assign stat_b = filt[WMON_PATH_B];

  AST_B_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(analog_good) && !$past(cfg_q.filter_en))
      |-> (stat_b == $past(cmp_b_raw))) // R2
    else $error("stat_b does not follow comparator B");

  AST_A_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(analog_good) && !$past(cfg_q.filter_en)
      && ($past(cfg_q.a_source) == ASRC_DIRECT))
      |-> (stat_a == $past(cmp_a_raw))) // R1
    else $error("stat_a does not follow comparator A");

  AST_A_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(analog_good) && !$past(cfg_q.filter_en)
      && ($past(cfg_q.a_source) == ASRC_WINDOW))
      |-> (stat_a == ($past(cmp_b_raw) && !$past(cmp_a_raw)))) // R3
    else $error("stat_a is not the window flag");

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(analog_good)) |-> (!stat_a && !stat_b)) // R6
    else $error("status reported while invalid");

endmodule

// File: tb/test_wmon_channel.sv
`timescale 1ns/1ps
module test_wmon_channel;

  localparam int unsigned LEN = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic analog_good;
  logic cfg_window_sel;
  logic cfg_filter_en;
  logic cmp_a_raw;
  logic cmp_b_raw;
  logic stat_a;
  logic stat_b;

  int checks   = 0;
  int failures = 0;
  string cur_req = "R8";

  always #2 clk = ~clk;

  wmon_channel #(.FILTER_LEN(LEN)) i_wmon_channel (
    .clk           (clk),
    .rst_n         (rst_n),
    .analog_good   (analog_good),
    .cfg_window_sel(cfg_window_sel),
    .cfg_filter_en (cfg_filter_en),
    .cmp_a_raw     (cmp_a_raw),
    .cmp_b_raw     (cmp_b_raw),
    .stat_a        (stat_a),
    .stat_b        (stat_b)
  );

  // Behavioural reference model
  int m_run[2];
  bit m_out[2];
  bit m_win;
  bit m_fen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run[0] = 0; m_run[1] = 0;
      m_out[0] = 0; m_out[1] = 0;
      m_win = 0; m_fen = 0;
    end else if (!analog_good) begin
      m_run[0] = 0; m_run[1] = 0;
      m_out[0] = 0; m_out[1] = 0;
      m_win = cfg_window_sel;
      m_fen = cfg_filter_en;
    end else begin
      bit want[2];
      int need;
      want[0] = m_win ? (cmp_b_raw && !cmp_a_raw) : cmp_a_raw;
      want[1] = cmp_b_raw;
      need = m_fen ? LEN : 1;
      for (int i = 0; i < 2; i++) begin
        if (want[i] == m_out[i]) begin
          m_run[i] = 0;
        end else begin
          m_run[i] = m_run[i] + 1;
          if (m_run[i] >= need) begin
            m_out[i] = want[i];
            m_run[i] = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(cur_req, stat_a, m_out[0], "model stat_a");
      chk(cur_req, stat_b, m_out[1], "model stat_b");
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Drop analog_good for one edge to load new configuration.
  task automatic reconfig(input bit win, input bit fen);
    analog_good    = 1'b0;
    cfg_window_sel = win;
    cfg_filter_en  = fen;
    step(1);
    analog_good = 1'b1;
  endtask

  bit timed_out = 0;
  bit done      = 0;

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      timed_out = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; analog_good = 1'b0;
    cfg_window_sel = 1'b0; cfg_filter_en = 1'b0;
    cmp_a_raw = 1'b0; cmp_b_raw = 1'b0;
    step(3);
    cur_req = "R8";
    chk("R8", stat_a, 1'b0, "reset stat_a");
    chk("R8", stat_b, 1'b0, "reset stat_b");
    rst_n = 1'b1;
    step(2);
    cur_req = "R6";
    cmp_a_raw = 1'b1; cmp_b_raw = 1'b1;
    step(3);
    chk("R6", stat_a, 1'b0, "invalid stat_a");
    chk("R6", stat_b, 1'b0, "invalid stat_b");

    // Direct mode, filter off
    cmp_a_raw = 1'b0; cmp_b_raw = 1'b0;
    analog_good = 1'b1;
    step(1);
    cur_req = "R1";
    cmp_a_raw = 1'b1;
    step(1);
    chk("R1", stat_a, 1'b1, "direct A above trip");
    chk("R4", stat_b, 1'b0, "unfiltered B low");
    cmp_b_raw = 1'b1;
    step(1);
    chk("R2", stat_b, 1'b1, "B above trip");

    // Config change while valid must not take effect
    cur_req = "R7";
    cfg_window_sel = 1'b1; cfg_filter_en = 1'b1;
    cmp_a_raw = 1'b0;
    step(1);
    chk("R7", stat_a, 1'b0, "window select ignored while valid");
    cmp_a_raw = 1'b1;
    step(1);
    chk("R7", stat_a, 1'b1, "filter enable ignored while valid");

    // Window mode, filter off
    cur_req = "R3";
    reconfig(1'b1, 1'b0);
    chk("R6", stat_b, 1'b0, "drop clears stat_b");
    cmp_a_raw = 1'b0; cmp_b_raw = 1'b0;
    step(1);
    chk("R3", stat_a, 1'b0, "below B");
    cmp_b_raw = 1'b1;
    step(1);
    chk("R3", stat_a, 1'b1, "between thresholds");
    chk("R2", stat_b, 1'b1, "B in window mode");
    cmp_a_raw = 1'b1;
    step(1);
    chk("R3", stat_a, 1'b0, "above A");

    // Filter on, direct mode
    cur_req = "R5";
    cmp_a_raw = 1'b0; cmp_b_raw = 1'b0;
    reconfig(1'b0, 1'b1);
    cmp_a_raw = 1'b1;
    step(LEN - 1);
    chk("R5", stat_a, 1'b0, "one sample short");
    step(1);
    chk("R5", stat_a, 1'b1, "qualified rise");
    cmp_a_raw = 1'b0;
    step(5);
    cmp_a_raw = 1'b1;
    step(1);
    cmp_a_raw = 1'b0;
    step(LEN - 1);
    chk("R5", stat_a, 1'b1, "bounce restarted count");
    step(1);
    chk("R5", stat_a, 1'b0, "qualified fall");

    // Partial count discarded by an invalid edge
    cur_req = "R6";
    cmp_a_raw = 1'b1; cmp_b_raw = 1'b1;
    step(LEN);
    chk("R5", stat_b, 1'b1, "filtered B rise");
    cmp_a_raw = 1'b0;
    step(1);
    cmp_a_raw = 1'b1;
    step(10);
    reconfig(1'b0, 1'b1);
    chk("R6", stat_b, 1'b0, "drop clears filtered B");
    step(LEN - 1);
    chk("R6", stat_a, 1'b0, "partial count not kept");
    step(1);
    chk("R6", stat_a, 1'b1, "full count after drop");

    // Random phase against the model
    cur_req = "R4";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) cmp_a_raw = ~cmp_a_raw;
      if ($urandom_range(0, 9) == 0) cmp_b_raw = ~cmp_b_raw;
      if ($urandom_range(0, 300) == 0) begin
        cur_req = "R7";
        cfg_window_sel = $urandom_range(0, 1);
        cfg_filter_en  = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 400) == 0) analog_good = ~analog_good;
      step(1);
    end

    // Asynchronous reset
    analog_good = 1'b1;
    cfg_window_sel = 1'b0;
    cmp_a_raw = 1'b1; cmp_b_raw = 1'b1;
    reconfig(1'b0, 1'b0);
    step(2);
    chk("R1", stat_a, 1'b1, "pre-reset A");
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8", stat_a, 1'b0, "async reset stat_a");
    chk("R8", stat_b, 1'b0, "async reset stat_b");
    step(2);
    rst_n = 1'b1;
    step(2);

    done = 1;
    if (!timed_out) finish_run();
  end

endmodule